// File: doc/BRIEF.md
# Fast Ethernet link status qualifier

This block decides whether a 100 Mb/s link is good. It combines three inputs: a flag saying the received signal level is valid, event pulses from the descrambler, and an external force request. A lock indication from the descrambler sets an internal locked flag. A watchdog then keeps the flag set for as long as idle or valid-symbol indications keep arriving. If no indication arrives within the selected window, the watchdog clears the flag. The window is either a short interval or a long one. The long interval lets very long frames pass without a false loss of lock.

Link status rises only when the signal is valid and the descrambler is locked. How the link is held afterwards depends on a mode input. In the lenient mode, a valid signal level alone keeps the link up. In the strict mode, the link also needs continued lock. Two overrides exist. Force-signal-detect makes the signal level look valid. Force-good-link, ORed with an external request, forces the link status output high. The block runs on one reference clock with a synchronous, active-high reset. The parameter `CLKS_PER_US` gives the number of reference cycles per microsecond.

The block has no streaming data path. All of its pins are plain level or pulse signals, and none of them has a handshake or back-pressure.

Top module: `fe_link_qualifier`

## Requirements
- R1: In the first cycle after reset is released, `link_up` and `dsc_locked` are 0, provided both force inputs are 0.
- R2: The internal link state rises only on a clock edge at which the effective signal detect is 1 and `dsc_locked` is already 1. The effective signal detect is `rx_level_ok` OR `cfg_force_sd`. A `dsc_lock_seen` pulse sampled at edge k therefore sets `dsc_locked` after edge k, and sets `link_up` after edge k+1.
- R3: With `cfg_hold_on_level`=1, an established link stays up while the effective signal detect stays 1, even when `dsc_locked` falls.
- R4: With `cfg_hold_on_level`=0, an established link falls at the first edge at which `dsc_locked` is 0.
- R5: In both modes, an effective signal detect of 0 at an edge clears the link at that edge.
- R6: With `cfg_long_timeout`=0, `dsc_locked` falls at the 722*CLKS_PER_US-th consecutive edge without an indication. An indication is a `dsc_lock_seen` or `dsc_sym_seen` pulse.
- R7: With `cfg_long_timeout`=1, the same drop happens at the 2000*CLKS_PER_US-th consecutive edge without an indication.
- R8: A `dsc_sym_seen` pulse while locked restarts the timeout window. Pulses spaced closer than the window keep `dsc_locked` at 1 indefinitely.
- R9: `link_up` is 1 in the same cycle that `cfg_force_good` or `force_link_req` is 1, regardless of any other input.
- R10: With `cfg_force_sd`=1 and `rx_level_ok`=0, the link is qualified exactly as if the signal level were valid.
- R11: While unlocked, `dsc_sym_seen` pulses have no effect. Only a `dsc_lock_seen` pulse sets `dsc_locked` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_level_ok | input | 1 | Received signal level valid |
| dsc_lock_seen | input | 1 | Descrambler lock-acquired pulse |
| dsc_sym_seen | input | 1 | Descrambler idle/valid-symbol pulse |
| force_link_req | input | 1 | External force-good-link request |
| cfg_hold_on_level | input | 1 | 1: hold link on signal level only; 0: also need lock |
| cfg_long_timeout | input | 1 | 1: long lock window; 0: short window |
| cfg_force_sd | input | 1 | Force signal detect valid |
| cfg_force_good | input | 1 | Force good link |
| link_up | output | 1 | 100 Mb/s link status |
| dsc_locked | output | 1 | Descrambler locked flag |

## Verification
On every cycle, the assertions check the link rules: the link rises only from a valid detect plus lock, falls on signal loss, and is held or dropped according to the mode. They also check that the locked flag is set only by a lock pulse and survives any cycle that carries an indication. Only the bench scenarios can show the exact length of both timeout windows and the restart of the window by symbol pulses. They also show the combinational effect of the force inputs on the output pin, and that symbol pulses cannot relock an unlocked descrambler.

// File: rtl/fe_lq_pkg.sv
package fe_lq_pkg;
  typedef enum logic {LQ_DOWN = 1'b0, LQ_UP = 1'b1} lq_state_e;

  function automatic int unsigned us_to_cycles(input int unsigned us,
                                               input int unsigned per_us);
    return us * per_us;
  endfunction
endpackage

// File: rtl/fe_lq_sig_detect.sv
module fe_lq_sig_detect (
  input  logic level_ok,
  input  logic force_sd,
  output logic sd_eff
);
  assign sd_eff = level_ok | force_sd;
endmodule

// File: rtl/fe_lq_lock_wdog.sv
module fe_lq_lock_wdog
  import fe_lq_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 125,
  parameter int unsigned SHORT_US    = 722,
  parameter int unsigned LONG_US     = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_seen,
  input  logic sym_seen,
  input  logic long_sel,
  output logic locked
);
  localparam int unsigned SHORT_CYC = us_to_cycles(SHORT_US, CLKS_PER_US);
  localparam int unsigned LONG_CYC  = us_to_cycles(LONG_US, CLKS_PER_US);
  localparam int unsigned MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_idx;
  logic          expire;

  // last count value before the window runs out
  assign last_idx = long_sel ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
  assign expire   = locked && !lock_seen && !sym_seen && (cnt_q >= last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      cnt_q  <= '0;
    end else if (lock_seen) begin
      locked <= 1'b1;
      cnt_q  <= '0;
    end else if (locked) begin
      if (sym_seen) begin
        cnt_q <= '0;
      end else if (expire) begin
        locked <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R11
  relock_only_by_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!locked && !lock_seen) |=> !locked);
  // R8
  indication_keeps_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && (sym_seen || lock_seen)) |=> locked);
  // R6
  drop_needs_silence_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(!sym_seen && !lock_seen));
endmodule

// File: rtl/fe_lq_link_fsm.sv
module fe_lq_link_fsm
  import fe_lq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sd_eff,
  input  logic locked,
  input  logic hold_on_level,
  output logic link_q
);
  lq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!sd_eff) begin
      st_d = LQ_DOWN;
    end else begin
      case (st_q)
        LQ_DOWN: if (locked) st_d = LQ_UP;
        LQ_UP:   if (!hold_on_level && !locked) st_d = LQ_DOWN;
        default: st_d = LQ_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= LQ_DOWN;
    else     st_q <= st_d;
  end

  assign link_q = (st_q == LQ_UP);

  // R2
  rise_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(link_q) |-> $past(sd_eff && locked));
  // R5
  level_loss_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !sd_eff |=> !link_q);
  // R4
  strict_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (link_q && !hold_on_level && !locked) |=> !link_q);
  // R3
  lenient_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (link_q && hold_on_level && sd_eff) |=> link_q);
  // R1
  reset_down_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !link_q);
endmodule

// File: rtl/fe_link_qualifier.sv
module fe_link_qualifier #(
  parameter int unsigned CLKS_PER_US = 125,
  parameter int unsigned SHORT_US    = 722,
  parameter int unsigned LONG_US     = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_level_ok,
  input  logic dsc_lock_seen,
  input  logic dsc_sym_seen,
  input  logic force_link_req,
  input  logic cfg_hold_on_level,
  input  logic cfg_long_timeout,
  input  logic cfg_force_sd,
  input  logic cfg_force_good,
  output logic link_up,
  output logic dsc_locked
);
  logic sd_eff;
  logic link_q;
  logic force_any;

  fe_lq_sig_detect u_sd (
    .level_ok (rx_level_ok),
    .force_sd (cfg_force_sd),
    .sd_eff   (sd_eff)
  );

  fe_lq_lock_wdog #(
    .CLKS_PER_US (CLKS_PER_US),
    .SHORT_US    (SHORT_US),
    .LONG_US     (LONG_US)
  ) u_wdog (
    .clk       (clk),
    .rst       (rst),
    .lock_seen (dsc_lock_seen),
    .sym_seen  (dsc_sym_seen),
    .long_sel  (cfg_long_timeout),
    .locked    (dsc_locked)
  );

  fe_lq_link_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .sd_eff        (sd_eff),
    .locked        (dsc_locked),
    .hold_on_level (cfg_hold_on_level),
    .link_q        (link_q)
  );

  assign force_any = cfg_force_good | force_link_req;
  assign link_up   = link_q | force_any;

  // R2
  unforced_up_needs_detect_chk: assert property (@(posedge clk) disable iff (rst)
    (!force_any && $rose(link_up)) |-> $past(sd_eff));
endmodule

// File: tb/tb_fe_link_qualifier.sv
module tb_fe_link_qualifier;
  localparam int unsigned CPU = 2;
  localparam int T_SHORT = 722 * CPU;
  localparam int T_LONG  = 2000 * CPU;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_level_ok = 0, dsc_lock_seen = 0, dsc_sym_seen = 0, force_link_req = 0;
  logic cfg_hold_on_level = 1, cfg_long_timeout = 0, cfg_force_sd = 0, cfg_force_good = 0;
  logic link_up, dsc_locked;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  fe_link_qualifier #(.CLKS_PER_US(CPU)) dut (
    .clk(clk), .rst(rst), .rx_level_ok(rx_level_ok), .dsc_lock_seen(dsc_lock_seen),
    .dsc_sym_seen(dsc_sym_seen), .force_link_req(force_link_req),
    .cfg_hold_on_level(cfg_hold_on_level), .cfg_long_timeout(cfg_long_timeout),
    .cfg_force_sd(cfg_force_sd), .cfg_force_good(cfg_force_good),
    .link_up(link_up), .dsc_locked(dsc_locked)
  );

  // behavioural reference model: time-stamp of last indication
  int  cyc = 0;
  int  last_ind = 0;
  bit  m_lock = 0;
  bit  m_link = 0;
  bit  started = 0;

  always @(posedge clk) begin
    bit nl, nk, sd;
    cyc++;
    started = 1;
    if (rst) begin
      nl = 0; nk = 0;
    end else begin
      nl = m_lock;
      if (dsc_lock_seen) begin nl = 1; last_ind = cyc; end
      else if (m_lock) begin
        if (dsc_sym_seen) last_ind = cyc;
        else if (cyc - last_ind >= (cfg_long_timeout ? T_LONG : T_SHORT)) nl = 0;
      end
      sd = rx_level_ok || cfg_force_sd;
      if (!sd) nk = 0;
      else if (!m_link) nk = m_lock;
      else nk = !( !cfg_hold_on_level && !m_lock );
    end
    m_lock = nl;
    m_link = nk;
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%b exp=%b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(cur_req, "link_up", link_up, m_link | cfg_force_good | force_link_req);
      chk(cur_req, "dsc_locked", dsc_locked, m_lock);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic pulse_lock();
    @(posedge clk); #2 dsc_lock_seen = 1;
    @(posedge clk); #2 dsc_lock_seen = 0;
  endtask

  task automatic pulse_sym();
    @(posedge clk); #2 dsc_sym_seen = 1;
    @(posedge clk); #2 dsc_sym_seen = 0;
  endtask

  task automatic probe(string req, string what, logic act, logic exp);
    @(negedge clk); #1 chk(req, what, act, exp);
  endtask

  initial begin
    step(4);
    rst = 0;
    step(1);
    // R1
    probe("R1", "link_up after reset", link_up, 1'b0);
    probe("R1", "dsc_locked after reset", dsc_locked, 1'b0);

    // R11: symbol pulses while unlocked do nothing
    cur_req = "R11";
    rx_level_ok = 1;
    pulse_sym(); pulse_sym();
    probe("R11", "locked after sym while unlocked", dsc_locked, 1'b0);

    // R2: lock then link one edge later
    cur_req = "R2";
    @(posedge clk); #2 dsc_lock_seen = 1;
    @(posedge clk); #2 dsc_lock_seen = 0;
    probe("R2", "locked one edge after pulse", dsc_locked, 1'b1);
    probe("R2", "link not yet up", link_up, 1'b0);
    step(1);
    probe("R2", "link up next edge", link_up, 1'b1);

    // R8: periodic symbols keep lock well beyond the short window
    cur_req = "R8";
    for (int k = 0; k < 30; k++) begin pulse_sym(); step(100); end
    probe("R8", "lock kept by symbols", dsc_locked, 1'b1);

    // R6 + R3: short window expiry, lenient hold keeps link
    cur_req = "R6";
    pulse_sym();
    step(T_SHORT - 1);
    probe("R6", "locked one before short window", dsc_locked, 1'b1);
    step(1);
    probe("R6", "unlocked at short window", dsc_locked, 1'b0);
    cur_req = "R3";
    step(20);
    probe("R3", "link held without lock", link_up, 1'b1);

    // R5: signal loss drops link at next edge
    cur_req = "R5";
    @(posedge clk); #2 rx_level_ok = 0;
    step(1);
    probe("R5", "link dropped on level loss", link_up, 1'b0);
    step(3);

    // R7 + R4: long window, strict mode
    cur_req = "R7";
    rx_level_ok = 1; cfg_hold_on_level = 0; cfg_long_timeout = 1;
    pulse_lock();
    step(2);
    probe("R4", "strict link up", link_up, 1'b1);
    pulse_sym();
    step(T_LONG - 1);
    probe("R7", "locked one before long window", dsc_locked, 1'b1);
    step(1);
    probe("R7", "unlocked at long window", dsc_locked, 1'b0);
    probe("R4", "strict link still up same cycle", link_up, 1'b1);
    cur_req = "R4";
    step(1);
    probe("R4", "strict link dropped after lock loss", link_up, 1'b0);

    // R10: forced signal detect with no signal
    cur_req = "R10";
    rx_level_ok = 0; cfg_force_sd = 1; cfg_hold_on_level = 1; cfg_long_timeout = 0;
    pulse_lock();
    step(2);
    probe("R10", "link up with forced detect", link_up, 1'b1);
    cfg_force_sd = 0;
    step(2);
    probe("R10", "link down once force removed", link_up, 1'b0);

    // R9: force inputs act combinationally
    cur_req = "R9";
    @(negedge clk); #1 cfg_force_good = 1;
    #1 chk("R9", "force_good same cycle", link_up, 1'b1);
    @(negedge clk); #1 cfg_force_good = 0; force_link_req = 1;
    #1 chk("R9", "force_link_req same cycle", link_up, 1'b1);
    @(negedge clk); #1 force_link_req = 0;
    #1 chk("R9", "released force", link_up, 1'b0);
    step(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1..: act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule